// File: doc/BRIEF.md
# Register-Mapped SPI Shift Engine

This block is an SPI host in mode 0 that software drives through a small 32-bit register window. Software writes an outgoing word of up to 32 bits, then writes a shift-control word. That word starts the transfer, chooses which of three active-low chip selects to drive, gives the bit count and says whether the select is released at the end. Software then polls a busy bit and reads the received word.

Each command carries its own select, count and terminate flag. A select stays driven across commands until a command with the terminate flag finishes, so one bus frame can be built from several short shifts. The serial clock rate is set by a 6-bit divider. When no frame owns the pins, they follow a static pin-level register whose reset value keeps every select high and the clock and data lines low.

Register offsets: 0x00 enable (bit 0), 0x04 divider (bits 5:0), 0x08 pin levels, 0x10 transmit word, 0x14 shift control, 0x18 receive word.

Top module: `spi_shift_host`

## Requirements
- R1: After reset, reads return 0 from 0x00, 0x04, 0x10 and 0x18 and 0x0007_0000 from 0x08. The pins show spi_cs_n = 3'b111, spi_sck = 0 and spi_mosi = 0.
- R2: Each high and each low phase of spi_sck lasts (D+1) clock cycles, where D is register 0x04 bits 5:0. An N-bit transfer therefore holds spi_sck high for N*(D+1) cycles.
- R3: A write to 0x14 with bit 31 set starts a transfer only while 0x00 bit 0 is 1. Bit 31 of 0x14 reads 1 while the transfer runs and 0 once all bits have shifted. With 0x00 bit 0 clear, such a write produces no clock edges and never reads busy.
- R4: Bits 28, 29 and 30 of the command drive spi_cs_n[0], [1] and [2] low for the whole transfer. The select falls at least one half-period before the first rising spi_sck edge.
- R5: With command bit 26 set, the select is released after the last bit. With it clear, the select stays low after the command until a later command with bit 26 set finishes.
- R6: The count in bits 6:0 gives N rising spi_sck edges. spi_mosi presents bit N-1 of the 0x10 word first and bit 0 last, changing only while spi_sck is low. Counts above 32 act as 32.
- R7: spi_miso is sampled at each rising spi_sck edge and shifted into 0x18 at bit 0. 0x18 is cleared when a transfer starts, so after N bits it holds them right-aligned, with the first received bit highest.
- R8: A command with count 0 never toggles spi_sck and never reads busy. With bit 26 set it releases a held select at once; with bit 26 clear it leaves the select as it was.
- R9: A write to 0x14 while busy is ignored. The running transfer keeps its bit count, and the stored command fields read back unchanged.
- R10: 0x18 keeps its value until the next transfer starts, regardless of writes to 0x10 or repeated reads.
- R11: While no frame owns the pins, spi_mosi follows 0x08 bit 0, spi_sck follows bit 8 and spi_cs_n follows bits 18:16.
- R12: reg_rdata takes the addressed register's value on the clock edge where reg_rd is 1, and holds it while reg_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 3 | Active-low chip selects |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench aims at the frame that spans two commands. A design that releases the select after an unterminated command would show the select high between the two shifts. A count above 32 is also covered: a design that did not clamp it would produce more than 32 clock edges or send bits from beyond the word. The bench also checks a zero-count command and a write issued while busy. A design that toggled the clock on a zero count, or restarted on the busy write, would show the wrong edge count or the wrong fields on readback. Finally, a slave model returns a known pattern, so a wrong sampling edge or a wrong shift direction would show up in the value read from 0x18.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIVIDE = 8'h04;
    localparam logic [ADDR_W-1:0] A_PINS   = 8'h08;
    localparam logic [ADDR_W-1:0] A_TXWORD = 8'h10;
    localparam logic [ADDR_W-1:0] A_SHIFT  = 8'h14;
    localparam logic [ADDR_W-1:0] A_RXWORD = 8'h18;
    localparam logic [31:0] PINS_RESET = 32'h0007_0000;
    localparam int SH_GO_BIT   = 31;
    localparam int SH_SEL_LSB  = 28;
    localparam int SH_TERM_BIT = 26;
    localparam int PIN_MOSI    = 0;
    localparam int PIN_SCK     = 8;
    localparam int PIN_SEL_LSB = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW
    } phase_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t d_d, d_q;

    always_comb begin
        d_d  = d_q;
        tick = run && (d_q.cnt == div);
        if (!run || tick) d_d.cnt = '0;
        else              d_d.cnt = d_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    // R2: the half-period counter never passes the programmed divider
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (d_q.cnt <= div));
endmodule

// File: rtl/spi_shift_seq.sv
module spi_shift_seq
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CS = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CS-1:0] cmd_sel,
    input  logic              cmd_term,
    input  logic [CNT_W-1:0]  cmd_cnt,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              owns,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] sel,
    output logic [DATA_W-1:0] rx_word
);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam int SEL_W = $clog2(DATA_W);

    typedef struct packed {
        phase_e            ph;
        logic              sck;
        logic              mosi;
        logic              held;
        logic              term;
        logic [NUM_CS-1:0] sel;
        logic [IDX_W-1:0]  rem;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W-1:0] eff;

    always_comb begin
        eff = (cmd_cnt > CNT_W'(DATA_W)) ? IDX_W'(DATA_W) : IDX_W'(cmd_cnt);
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (eff == '0) begin
                        if (cmd_term) s_d.held = 1'b0;
                    end else begin
                        s_d.ph   = PH_LEAD;
                        s_d.sel  = cmd_sel;
                        s_d.term = cmd_term;
                        s_d.held = 1'b1;
                        s_d.rem  = eff;
                        s_d.tx   = tx_word;
                        s_d.rx   = '0;
                        s_d.sck  = 1'b0;
                        s_d.mosi = tx_word[SEL_W'(eff - IDX_W'(1))];
                    end
                end
            end
            PH_LEAD, PH_LOW: begin
                if (tick) begin
                    s_d.sck = 1'b1;
                    s_d.rx  = {s_q.rx[DATA_W-2:0], miso};
                    s_d.rem = s_q.rem - 1'b1;
                    s_d.ph  = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    s_d.sck = 1'b0;
                    if (s_q.rem == '0) begin
                        s_d.ph   = PH_IDLE;
                        s_d.held = !s_q.term;
                    end else begin
                        s_d.mosi = s_q.tx[SEL_W'(s_q.rem - IDX_W'(1))];
                        s_d.ph   = PH_LOW;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.ph != PH_IDLE);
    assign owns    = busy || s_q.held;
    assign sck     = s_q.sck;
    assign mosi    = s_q.mosi;
    assign sel     = s_q.sel;
    assign rx_word = s_q.rx;

    // R2: the serial clock only moves on a divider tick
    p_sck_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(s_q.sck));
    // R4: the selected line does not change during a transfer
    p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.sel));
    // R9: the register decode never starts a command while busy
    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R6: the remaining count stays within one word
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rem <= IDX_W'(DATA_W));
    // R8: the clock rests low whenever no transfer runs
    p_idle_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !s_q.sck);
endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CS = 3,
    parameter int DIV_W  = 6,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs_n,
    input  logic              spi_miso
);
    typedef struct packed {
        logic              enable;
        logic [DIV_W-1:0]  div;
        logic [31:0]       pins;
        logic [DATA_W-1:0] txw;
        logic [NUM_CS-1:0] sh_sel;
        logic              sh_term;
        logic [CNT_W-1:0]  sh_cnt;
        logic [31:0]       rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic start, tick, busy, owns, seq_sck, seq_mosi;
    logic [NUM_CS-1:0] seq_sel;
    logic [DATA_W-1:0] rx_word;
    logic [31:0] shift_rd, rd_mux;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;

        shift_rd = '0;
        shift_rd[SH_GO_BIT] = busy;
        shift_rd[SH_SEL_LSB +: NUM_CS] = r_q.sh_sel;
        shift_rd[SH_TERM_BIT] = r_q.sh_term;
        shift_rd[CNT_W-1:0] = r_q.sh_cnt;

        unique case (reg_addr)
            A_ENABLE: rd_mux = 32'(r_q.enable);
            A_DIVIDE: rd_mux = 32'(r_q.div);
            A_PINS:   rd_mux = r_q.pins;
            A_TXWORD: rd_mux = 32'(r_q.txw);
            A_SHIFT:  rd_mux = shift_rd;
            A_RXWORD: rd_mux = 32'(rx_word);
            default:  rd_mux = '0;
        endcase
        if (reg_rd) r_d.rdata = rd_mux;

        if (reg_wr) begin
            unique case (reg_addr)
                A_ENABLE: r_d.enable = reg_wdata[0];
                A_DIVIDE: r_d.div    = reg_wdata[DIV_W-1:0];
                A_PINS:   r_d.pins   = reg_wdata;
                A_TXWORD: r_d.txw    = reg_wdata[DATA_W-1:0];
                A_SHIFT: begin
                    if (!busy) begin
                        r_d.sh_sel  = reg_wdata[SH_SEL_LSB +: NUM_CS];
                        r_d.sh_term = reg_wdata[SH_TERM_BIT];
                        r_d.sh_cnt  = reg_wdata[CNT_W-1:0];
                        start       = reg_wdata[SH_GO_BIT] && r_q.enable;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.pins <= PINS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (r_q.div),
        .tick (tick)
    );

    spi_shift_seq #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd_sel (reg_wdata[SH_SEL_LSB +: NUM_CS]),
        .cmd_term(reg_wdata[SH_TERM_BIT]),
        .cmd_cnt (reg_wdata[CNT_W-1:0]),
        .tx_word (r_q.txw),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .owns    (owns),
        .sck     (seq_sck),
        .mosi    (seq_mosi),
        .sel     (seq_sel),
        .rx_word (rx_word)
    );

    assign reg_rdata = r_q.rdata;
    assign spi_sck   = owns ? seq_sck  : r_q.pins[PIN_SCK];
    assign spi_mosi  = owns ? seq_mosi : r_q.pins[PIN_MOSI];
    assign spi_cs_n  = owns ? ~seq_sel : r_q.pins[PIN_SEL_LSB +: NUM_CS];

    // R12: read data only moves on a read strobe
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/spi_shift_host_test.sv
`timescale 1ns/1ps
module spi_shift_host_test;
    import spi_host_pkg::*;

    localparam logic [31:0] GO   = 32'h8000_0000;
    localparam logic [31:0] TERM = 32'h0400_0000;
    localparam logic [31:0] CS0  = 32'h1000_0000;
    localparam logic [31:0] CS1  = 32'h2000_0000;
    localparam logic [31:0] CS2  = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic spi_sck, spi_mosi, spi_miso;
    logic [2:0] spi_cs_n;

    int checks = 0;
    int fails  = 0;

    // slave model and monitors
    int unsigned edges = 0, e_base = 0, hicnt = 0, lead = 0;
    logic [31:0] slv_data = '0;
    logic [31:0] slv_rx = '0;
    logic [4:0] sidx;

    always #10 clk = ~clk;

    spi_shift_host uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso)
    );

    assign sidx     = 5'd31 - 5'(edges - e_base);
    assign spi_miso = slv_data[sidx];

    always @(posedge spi_sck) begin
        if (rst_n) begin
            edges  <= edges + 1;
            slv_rx <= {slv_rx[30:0], spi_mosi};
        end
    end

    always @(negedge clk) begin
        if (rst_n && spi_sck && spi_cs_n != 3'b111) hicnt <= hicnt + 1;
        if (rst_n && spi_cs_n != 3'b111 && edges == e_base) lead <= lead + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(A_SHIFT, v);
            if (!v[31]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 cs_n", 32'(spi_cs_n), 32'h7);
        check("R1 sck", 32'(spi_sck), 32'h0);
        check("R1 mosi", 32'(spi_mosi), 32'h0);
        rd(A_PINS, v);   check("R1 pins reg", v, 32'h0007_0000);
        rd(A_ENABLE, v); check("R1 enable reg", v, 32'h0);
        rd(A_DIVIDE, v); check("R1 divider reg", v, 32'h0);
        rd(A_RXWORD, v); check("R1 rx reg", v, 32'h0);
        wr(A_DIVIDE, 32'h9);
        @(negedge clk);
        check("R12 rdata holds without strobe", reg_rdata, 32'h0);
    endtask

    task automatic t_idle_pins();
        wr(A_PINS, 32'h0006_0101);
        check("R11 cs_n follows pin reg", 32'(spi_cs_n), 32'h6);
        check("R11 sck follows pin reg", 32'(spi_sck), 32'h1);
        check("R11 mosi follows pin reg", 32'(spi_mosi), 32'h1);
        wr(A_PINS, 32'h0007_0000);
        check("R11 pins restored", {spi_cs_n, spi_sck, spi_mosi}, {27'h0, 3'b111, 2'b00});
    endtask

    task automatic t_no_enable();
        logic [31:0] v;
        int unsigned e0 = edges;
        wr(A_ENABLE, 32'h0);
        wr(A_SHIFT, GO | CS0 | TERM | 32'd8);
        rd(A_SHIFT, v);
        check("R3 no busy when disabled", 32'(v[31]), 32'h0);
        repeat (40) @(negedge clk);
        check("R3 no edges when disabled", edges - e0, 32'h0);
        check("R3 select idle when disabled", 32'(spi_cs_n), 32'h7);
        wr(A_ENABLE, 32'h1);
    endtask

    task automatic t_basic8();
        logic [31:0] v;
        int unsigned e0, h0, l0;
        wr(A_DIVIDE, 32'd2);
        wr(A_TXWORD, 32'h0000_00A5);
        slv_data = 32'h3C00_0000;
        e_base = edges; e0 = edges; h0 = hicnt; l0 = lead;
        wr(A_SHIFT, GO | CS1 | TERM | 32'd8);
        check("R4 cs1 low during transfer", 32'(spi_cs_n), 32'h5);
        rd(A_SHIFT, v);
        check("R3 busy reads 1", 32'(v[31]), 32'h1);
        wait_idle();
        check("R6 eight edges", edges - e0, 32'd8);
        check("R6 msb-first tx", slv_rx & 32'hFF, 32'hA5);
        check("R2 high time 8*(2+1)", hicnt - h0, 32'd24);
        check("R4 lead >= half period", 32'(lead - l0 >= 3), 32'h1);
        rd(A_RXWORD, v);
        check("R7 rx right-aligned", v, 32'h0000_003C);
        check("R5 released after terminate", 32'(spi_cs_n), 32'h7);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wr(A_DIVIDE, 32'd1);
        wr(A_TXWORD, 32'h0000_1234);
        slv_data = 32'hBEEF_1200;
        e_base = edges;
        wr(A_SHIFT, GO | CS0 | 32'd16);
        wait_idle();
        check("R5 select held without terminate", 32'(spi_cs_n), 32'h6);
        rd(A_RXWORD, v);
        check("R7 first rx 16 bits", v, 32'h0000_BEEF);
        repeat (10) @(negedge clk);
        check("R5 select still held", 32'(spi_cs_n), 32'h6);
        wr(A_TXWORD, 32'h0000_0056);
        wr(A_SHIFT, GO | CS0 | TERM | 32'd8);
        wait_idle();
        check("R5 frame spans two commands", slv_rx & 32'h00FF_FFFF, 32'h0012_3456);
        rd(A_RXWORD, v);
        check("R7 rx cleared at start", v, 32'h0000_0012);
        check("R5 released after second", 32'(spi_cs_n), 32'h7);
    endtask

    task automatic t_over32();
        logic [31:0] v;
        int unsigned e0, h0;
        wr(A_DIVIDE, 32'd0);
        wr(A_TXWORD, 32'hDEAD_BEEF);
        slv_data = 32'hC001_D00D;
        e_base = edges; e0 = edges; h0 = hicnt;
        wr(A_SHIFT, GO | CS2 | TERM | 32'd40);
        wait_idle();
        check("R6 count 40 clamps to 32", edges - e0, 32'd32);
        check("R6 full word out", slv_rx, 32'hDEAD_BEEF);
        check("R2 high time at divider 0", hicnt - h0, 32'd32);
        rd(A_RXWORD, v);
        check("R7 full word in", v, 32'hC001_D00D);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int unsigned e0;
        wr(A_DIVIDE, 32'd1);
        slv_data = 32'h0;
        e_base = edges;
        wr(A_SHIFT, GO | CS2 | 32'd8);
        wait_idle();
        check("R5 cs2 held", 32'(spi_cs_n), 32'h3);
        e0 = edges;
        wr(A_SHIFT, GO | CS2 | 32'd0);
        check("R8 zero count no terminate keeps select", 32'(spi_cs_n), 32'h3);
        wr(A_SHIFT, GO | CS2 | TERM | 32'd0);
        check("R8 zero count terminate releases", 32'(spi_cs_n), 32'h7);
        rd(A_SHIFT, v);
        check("R8 zero count not busy", 32'(v[31]), 32'h0);
        repeat (10) @(negedge clk);
        check("R8 zero count no edges", edges - e0, 32'h0);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        int unsigned e0;
        wr(A_DIVIDE, 32'd5);
        wr(A_TXWORD, 32'h0000_0081);
        e_base = edges; e0 = edges;
        wr(A_SHIFT, GO | CS1 | TERM | 32'd8);
        wr(A_SHIFT, GO | CS0 | 32'd16);
        wait_idle();
        check("R9 busy write no extra edges", edges - e0, 32'd8);
        rd(A_SHIFT, v);
        check("R9 fields unchanged", v, CS1 | TERM | 32'd8);
        check("R9 select released", 32'(spi_cs_n), 32'h7);
    endtask

    task automatic t_rx_hold();
        logic [31:0] v1, v2;
        wr(A_DIVIDE, 32'd0);
        slv_data = 32'h5A00_0000;
        e_base = edges;
        wr(A_SHIFT, GO | CS0 | TERM | 32'd8);
        wait_idle();
        rd(A_RXWORD, v1);
        wr(A_TXWORD, 32'hFFFF_FFFF);
        rd(A_RXWORD, v2);
        check("R10 rx first read", v1, 32'h0000_005A);
        check("R10 rx holds after tx write", v2, 32'h0000_005A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_pins();
        t_no_enable();
        t_basic8();
        t_hold();
        t_over32();
        t_zero();
        t_busy_write();
        t_rx_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule